// File: doc/BRIEF.md
# Circular-Buffer Serial Audio Transmitter

This block is a transmit-only audio serial master. It plays an endless stream of 16-bit PCM stereo samples out of an on-chip word buffer. A bit clock arrives from outside the block, typically a timer output routed back in. The block passes it through a synchroniser and acts on each falling edge. On those edges it drives the data line MSB first and drives the channel-select line with the usual one-bit lead. Even buffer addresses carry left-channel samples and odd addresses carry right-channel samples.

The buffer is split into a lower half and an upper half. The block raises a sticky event when it takes the last word of the lower half and another when it takes the last word of the upper half. The host then refills whichever half is now idle, using a simple write port, while playback moves on through the other half. After the top word the read pointer returns to address 0 with no pause. Dropping the run control silences the outputs and rewinds the pointer, and the event flags keep their values.

Top module: `i2s_tx_pingpong`

## Requirements
- R1: After reset, `ws_out`, `sd_out`, `irq_half` and `irq_full` are all 0.
- R2: While `run` is 0, falling edges on `sck_in` have no effect: `ws_out` and `sd_out` stay 0 and the read pointer stays at address 0.
- R3: While `run` is 1, each synchronised falling edge of `sck_in` updates `sd_out` with the next data bit. Each 16-bit word is sent MSB first. Words are taken from consecutive addresses starting at 0, and each word fills one 16-edge slot.
- R4: `ws_out` is 0 during the slot of a word from an even address (left) and 1 during the slot of a word from an odd address (right). It changes on the edge that carries the LSB of the previous word, one edge before the MSB of the new word.
- R5: After the word at address DEPTH-1 is taken, the next word comes from address 0 in the very next slot.
- R6: `irq_half` is set in the cycle the word at address DEPTH/2-1 is taken, and stays 1 until cleared.
- R7: `irq_full` is set in the cycle the word at address DEPTH-1 is taken, and stays 1 until cleared.
- R8: A 1 on `clr_half` or `clr_full` clears the matching flag on the next clock. If a set and a clear hit the same cycle, the set wins.
- R9: Dropping `run` forces `ws_out` and `sd_out` to 0 on the next clock and keeps both flags. Raising `run` again restarts playback with the left word at address 0.
- R10: A word written through `wr_en`/`wr_addr`/`wr_data` while playback runs is the one sent when the pointer later reaches that address.
- R11: `ws_out` and `sd_out` change only in the clock cycle that follows a detected falling edge, or when `run` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start (1) / stop-and-rewind (0) control |
| sck_in | input | 1 | Externally generated bit clock, asynchronous to clk |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(DEPTH) | Buffer word address to write |
| wr_data | input | WORD_W | Sample word to write |
| clr_half | input | 1 | Clear request for the lower-half-consumed flag |
| clr_full | input | 1 | Clear request for the upper-half-consumed flag |
| ws_out | output | 1 | Channel select (0 left, 1 right) |
| sd_out | output | 1 | Serial data, MSB first |
| irq_half | output | 1 | Sticky flag: lower half consumed |
| irq_full | output | 1 | Sticky flag: upper half consumed |

## Verification
The host's flag clear can arrive in the same clock as the word load that sets that flag, and this collision is the case of interest. The bench drives the bit clock one system-clock phase at a time, so it knows the exact cycle in which the synchronised falling edge takes the word at address DEPTH/2-1. In that cycle it pulses `clr_half`. `irq_half` must then read 1 afterwards, because a refill event must not be lost. A separate clear pulse with no set pending must bring the flag to 0.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int DEF_WORD_W      = 16;
    localparam int DEF_DEPTH       = 512;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

endpackage

// File: rtl/i2s_tx_edge.sv
// Brings the external bit clock into the clk domain and flags its falling edges.
module i2s_tx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic fall_evt
);

    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], sck_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Oldest stage high, next-newer stage low: a high-to-low transition.
    assign fall_evt = st_q.sh[SH_W-1] & ~st_q.sh[SH_W-2];

endmodule

// File: rtl/i2s_tx_mem.sv
// Sample store: one synchronous host write port, one combinational read port.
module i2s_tx_mem #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_addr];

endmodule

// File: rtl/i2s_tx_ptr.sv
// Read pointer with wrap and the two sticky half-consumed flags.
module i2s_tx_ptr #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic          clr_half,
    input  logic          clr_full,
    output logic [AW-1:0] rd_addr,
    output logic          irq_half,
    output logic          irq_full
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          half;
        logic          full;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic    at_half_end;
    logic    at_top;

    always_comb begin
        st_d        = st_q;
        at_half_end = (st_q.addr == AW'(HALF - 1));
        at_top      = (st_q.addr == AW'(DEPTH - 1));

        if (!run) begin
            st_d.addr = '0;
        end else if (load) begin
            st_d.addr = at_top ? '0 : st_q.addr + AW'(1);
        end

        // Clear first, set afterwards: a set in the same cycle wins.
        if (clr_half) st_d.half = 1'b0;
        if (clr_full) st_d.full = 1'b0;
        if (run && load && at_half_end) st_d.half = 1'b1;
        if (run && load && at_top)      st_d.full = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr  = st_q.addr;
    assign irq_half = st_q.half;
    assign irq_full = st_q.full;

endmodule

// File: rtl/i2s_tx_ser.sv
// Slot counter, shift register and channel-select generator.
module i2s_tx_ser #(
    parameter int WORD_W = 16,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int POS_W = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall_evt,
    input  logic [WORD_W-1:0] word_in,
    output logic              load,
    output logic              ws,
    output logic              sd
);

    import i2s_tx_pkg::*;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [WORD_W-1:0] sh;
        chan_e             ws;
        logic              sd;
    } ser_st_t;

    ser_st_t          st_d, st_q;
    logic [POS_W-1:0] pos_nx;

    always_comb begin
        st_d   = st_q;
        load   = 1'b0;
        pos_nx = st_q.pos + POS_W'(1);

        if (!run) begin
            st_d.pos = '1;
            st_d.sh  = '0;
            st_d.ws  = CH_LEFT;
            st_d.sd  = 1'b0;
        end else if (fall_evt) begin
            st_d.pos = pos_nx;
            if (pos_nx[BIT_W-1:0] == '0) begin
                load    = 1'b1;
                st_d.sd = word_in[WORD_W-1];
                st_d.sh = {word_in[WORD_W-2:0], 1'b0};
            end else begin
                st_d.sd = st_q.sh[WORD_W-1];
                st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
            end
            // Channel select leads the data by one edge.
            if (pos_nx[BIT_W-1:0] == '1) begin
                st_d.ws = chan_e'(~pos_nx[POS_W-1]);
            end else begin
                st_d.ws = chan_e'(pos_nx[POS_W-1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ws = st_q.ws;
    assign sd = st_q.sd;

endmodule

// File: rtl/i2s_tx_pingpong.sv
module i2s_tx_pingpong #(
    parameter int WORD_W      = i2s_tx_pkg::DEF_WORD_W,
    parameter int DEPTH       = i2s_tx_pkg::DEF_DEPTH,
    parameter int SYNC_STAGES = i2s_tx_pkg::DEF_SYNC_STAGES,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sck_in,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_half,
    input  logic              clr_full,
    output logic              ws_out,
    output logic              sd_out,
    output logic              irq_half,
    output logic              irq_full
);

    logic              fall_evt;
    logic              load;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_word;

    i2s_tx_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_in  (sck_in),
        .fall_evt(fall_evt)
    );

    i2s_tx_mem #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH)
    ) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_word)
    );

    i2s_tx_ptr #(
        .DEPTH(DEPTH)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .load    (load),
        .clr_half(clr_half),
        .clr_full(clr_full),
        .rd_addr (rd_addr),
        .irq_half(irq_half),
        .irq_full(irq_full)
    );

    i2s_tx_ser #(
        .WORD_W(WORD_W)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .fall_evt(fall_evt),
        .word_in (rd_word),
        .load    (load),
        .ws      (ws_out),
        .sd      (sd_out)
    );

endmodule

// File: rtl/i2s_tx_pingpong_chk.sv
module i2s_tx_pingpong_chk #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          fall_evt,
    input logic          load,
    input logic [AW-1:0] rd_addr,
    input logic          clr_half,
    input logic          clr_full,
    input logic          ws_out,
    input logic          sd_out,
    input logic          irq_half,
    input logic          irq_full
);

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!ws_out && !sd_out));

    p_ptr_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (rd_addr == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fall_evt) |=> ($stable(ws_out) && $stable(sd_out)));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load && rd_addr == AW'(DEPTH - 1)) |=> (rd_addr == '0));

    p_half_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load && rd_addr == AW'(HALF - 1)) |=> irq_half);

    p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load && rd_addr == AW'(DEPTH - 1)) |=> irq_full);

    p_half_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_half && !clr_half) |=> irq_half);

    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_full && !clr_full) |=> irq_full);

    p_half_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_half && !(run && load && rd_addr == AW'(HALF - 1))) |=> !irq_half);

    p_full_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_full && !(run && load && rd_addr == AW'(DEPTH - 1))) |=> !irq_full);

endmodule

bind i2s_tx_pingpong i2s_tx_pingpong_chk #(
    .DEPTH(DEPTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .fall_evt(fall_evt),
    .load    (load),
    .rd_addr (rd_addr),
    .clr_half(clr_half),
    .clr_full(clr_full),
    .ws_out  (ws_out),
    .sd_out  (sd_out),
    .irq_half(irq_half),
    .irq_full(irq_full)
);

// File: tb/i2s_tx_pingpong_tb.sv
module i2s_tx_pingpong_tb;

    localparam int W     = 16;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          sck_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          clr_half = 1'b0;
    logic          clr_full = 1'b0;
    logic          ws_out, sd_out, irq_half, irq_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Requirement-level model state
    logic [W-1:0]  m_mem [DEPTH];
    int            m_pos;
    int            m_addr;
    logic [W-1:0]  m_sh;
    logic          m_ws, m_sd, m_half, m_full;

    always #5 clk = ~clk;

    i2s_tx_pingpong #(
        .WORD_W(W),
        .DEPTH (DEPTH)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sck_in  (sck_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clr_half(clr_half),
        .clr_full(clr_full),
        .ws_out  (ws_out),
        .sd_out  (sd_out),
        .irq_half(irq_half),
        .irq_full(irq_full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_rewind();
        m_pos  = 2 * W - 1;
        m_addr = 0;
        m_sh   = '0;
        m_ws   = 1'b0;
        m_sd   = 1'b0;
    endtask

    task automatic model_edge(input bit clr_h);
        int p;
        p = (m_pos + 1) % (2 * W);
        if (clr_h) m_half = 1'b0;
        if (p % W == 0) begin
            m_sd = m_mem[m_addr][W-1];
            m_sh = m_mem[m_addr] << 1;
            if (m_addr == HALF - 1)  m_half = 1'b1;
            if (m_addr == DEPTH - 1) m_full = 1'b1;
            m_addr = (m_addr + 1) % DEPTH;
        end else begin
            m_sd = m_sh[W-1];
            m_sh = m_sh << 1;
        end
        m_ws  = (((p + 1) % (2 * W)) >= W);
        m_pos = p;
    endtask

    // One bit-clock period; the falling edge is registered at the third
    // posedge after sck drops (two sync stages + output register).
    task automatic tick(input bit clr_h_evt, input string req);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
        sck_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (clr_h_evt) clr_half = 1'b1;
        @(negedge clk);
        clr_half = 1'b0;
        @(negedge clk);
        if (run) model_edge(clr_h_evt);
        check({req, " sd"}, sd_out, m_sd);
        check({req, " ws"}, ws_out, m_ws);
        check({req, " irq_half"}, irq_half, m_half);
        check({req, " irq_full"}, irq_full, m_full);
    endtask

    task automatic write_word(input int a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        m_mem[a] = d;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_half = 1'b0;
        m_full = 1'b0;
        model_rewind();
        check("R1 ws_out", ws_out, 1'b0);
        check("R1 sd_out", sd_out, 1'b0);
        check("R1 irq_half", irq_half, 1'b0);
        check("R1 irq_full", irq_full, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            write_word(i, W'((i * 16'h3A5D) ^ 16'hC3A1));
        end
    endtask

    task automatic t_stopped();
        for (int i = 0; i < 6; i++) tick(1'b0, "R2 stopped");
        run = 1'b1;
        model_rewind();
        // First left word must come from address 0, not a later one.
        for (int i = 0; i < 16; i++) tick(1'b0, "R2 start at addr0");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 80; i++) tick(1'b0, "R3/R4 stream");
    endtask

    task automatic t_wrap_flags();
        int guard = 0;
        while (!(m_full && m_addr == 1) && guard < 600) begin
            tick(1'b0, "R5/R6/R7 wrap");
            guard++;
        end
        check("R7 full flag seen", irq_full, 1'b1);
        check("R6 half flag seen", irq_half, 1'b1);
        for (int i = 0; i < 20; i++) tick(1'b0, "R5 after wrap");
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_half = 1'b1;
        clr_full = 1'b1;
        @(negedge clk);
        clr_half = 1'b0;
        clr_full = 1'b0;
        m_half = 1'b0;
        m_full = 1'b0;
        check("R8 clear half", irq_half, 1'b0);
        check("R8 clear full", irq_full, 1'b0);
    endtask

    task automatic t_collision();
        int guard = 0;
        while (!(((m_pos + 1) % W == 0) && m_addr == HALF - 1) && guard < 600) begin
            tick(1'b0, "R8 approach");
            guard++;
        end
        check("R8 flag low before collision", irq_half, 1'b0);
        tick(1'b1, "R8 set beats clear");
        check("R8 set wins", irq_half, 1'b1);
    endtask

    task automatic t_restart();
        for (int i = 0; i < 5; i++) tick(1'b0, "R9 mid word");
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R9 stop ws", ws_out, 1'b0);
        check("R9 stop sd", sd_out, 1'b0);
        check("R9 flags kept half", irq_half, m_half);
        check("R9 flags kept full", irq_full, m_full);
        run = 1'b1;
        model_rewind();
        for (int i = 0; i < 40; i++) tick(1'b0, "R9 restart");
    endtask

    task automatic t_write_mid();
        int tgt;
        tgt = (m_addr + 1) % DEPTH;
        write_word(tgt, 16'h8001);
        write_word((tgt + 1) % DEPTH, 16'h7FFE);
        for (int i = 0; i < 80; i++) tick(1'b0, "R10 live write");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stopped();
        t_stream();
        t_wrap_flags();
        t_clear();
        t_collision();
        t_restart();
        t_write_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule